// File: doc/BRIEF.md
# Byte ALU with Packed Condition Flags

This unit computes the simple arithmetic, logic and rotate operations of a small 8-bit processor and keeps the eight-bit condition register those operations update. A three-bit select picks one of eight operations: increment or decrement of a byte operand, AND, OR or XOR of the accumulator with a byte operand, a rotate of the accumulator left through carry, a circular rotate of the accumulator, and a 16-bit add of two wide operands. The byte result and the 16-bit sum are combinational outputs. The flag register changes only on a clock edge.

Each operation has its own rule for every flag. Flags an operation does not touch keep their previous value. The zero flag is held internally as the last result byte and reads as set when that byte is zero. A load port lets the surrounding pipeline write the whole flag byte back, for example when it restores a saved status word. The result of a logic operation is meant to be written into the accumulator by the caller.

Top module: `alu8_flagcore`

## Requirements
- R1: Bit 7 of flag_byte is sign, bit 6 zero, bit 5 a copy of a result bit, bit 4 half-carry, bit 3 a copy of a result bit, bit 2 parity/overflow, bit 1 subtract and bit 0 carry. After reset flag_byte reads 0x00.
- R2: With op_sel=0 (increment), res_byte = opnd_in+1 mod 256. Sign is result bit 7, zero is set when the result is 0, and bits 5 and 3 copy the result. Half-carry is set when the low nibble of opnd_in is 0xF. Overflow is set only for opnd_in=0x7F. Subtract is cleared and carry is unchanged.
- R3: With op_sel=1 (decrement), res_byte = opnd_in-1 mod 256. Sign, zero and the copy bits follow the R2 rules. Half-carry is set when the low nibble of opnd_in is 0. Overflow is set only for opnd_in=0x80. Subtract is set and carry is unchanged.
- R4: With op_sel=2, 3 or 4, res_byte is acc_in AND, OR or XOR opnd_in, with sign, zero and copy bits taken from the result. Carry and subtract are cleared. Half-carry is set for AND and cleared for OR and XOR.
- R5: For the three logic operations, bit 2 is 1 when the result holds an even number of one bits and 0 otherwise.
- R6: With op_sel=5, res_byte = {acc_in[6:0], old carry} and the new carry is acc_in[7]. Half-carry and subtract are cleared, bits 5 and 3 copy the result, and sign, zero and parity are unchanged.
- R7: With op_sel=6, res_byte = {acc_in[6:0], acc_in[7]} and the new carry is acc_in[7]. The other flags follow the R6 rules.
- R8: With op_sel=7, res_wide = wide_a+wide_b mod 65536. Carry is bit 16 of the full sum and half-carry is the carry out of bit 11. Bits 5 and 3 copy sum bits 13 and 11. Subtract is cleared, and sign, zero and parity are unchanged.
- R9: When flag_ld is high, the next edge loads flag_ld_data into the flag register so that flag_byte equals it bit for bit. This takes priority over upd_en.
- R10: When both upd_en and flag_ld are low, flag_byte keeps its value at the next edge, whatever op_sel and the operands are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| upd_en | input | 1 | Commit the selected operation's flags at the next edge |
| op_sel | input | 3 | Operation select (codes as in R2 to R8) |
| acc_in | input | 8 | Accumulator operand |
| opnd_in | input | 8 | Byte operand |
| wide_a | input | 16 | First operand of the wide add |
| wide_b | input | 16 | Second operand of the wide add |
| flag_ld | input | 1 | Load the flag register from flag_ld_data |
| flag_ld_data | input | 8 | Flag byte to load |
| res_byte | output | 8 | Byte result of operations 0 to 6 |
| res_wide | output | 16 | Sum of wide_a and wide_b |
| flag_byte | output | 8 | Packed flag register |

## Verification
The assertions assume that upd_en, flag_ld and op_sel are never unknown and that they stay stable across each rising edge. All eight op_sel codes are legal, so no code needs to be excluded. The bench changes every input only on the falling edge, and before each committed operation it loads a varied flag byte through flag_ld. This lets the flags an operation should preserve, and the old carry a rotate consumes, take both values. The sweeps cover every byte operand for increment and decrement, every operand against sixteen accumulator values for the logic operations, every accumulator with both carry values for the rotates, and pseudo-random wide operands together with the carry and half-carry edge sums.

// File: rtl/alu8_pkg.sv
package alu8_pkg;
  localparam int DW = 8;
  localparam int WW = 2 * DW;
  localparam int HB = (WW * 3) / 4;
  localparam logic [DW-1:0] ONE     = {{(DW-1){1'b0}}, 1'b1};
  localparam logic [DW-1:0] POS_MAX = {1'b0, {(DW-1){1'b1}}};
  localparam logic [DW-1:0] NEG_MIN = {1'b1, {(DW-1){1'b0}}};

  typedef enum logic [2:0] {
    OP_INC  = 3'd0,
    OP_DEC  = 3'd1,
    OP_AND  = 3'd2,
    OP_OR   = 3'd3,
    OP_XOR  = 3'd4,
    OP_RLT  = 3'd5,
    OP_RLC  = 3'd6,
    OP_ADDW = 3'd7
  } alu_op_e;

  typedef struct packed {
    logic          s;
    logic [DW-1:0] zval;
    logic          b5;
    logic          h;
    logic          b3;
    logic          pv;
    logic          n;
    logic          c;
  } flag_state_t;
endpackage

// File: rtl/alu8_bytepath.sv
module alu8_bytepath
  import alu8_pkg::*;
(
  input  alu_op_e       op,
  input  logic [DW-1:0] acc,
  input  logic [DW-1:0] opnd,
  input  flag_state_t   cur,
  output logic [DW-1:0] res,
  output flag_state_t   nxt
);
  always_comb begin
    nxt = cur;
    res = '0;
    case (op)
      OP_INC: begin
        res    = opnd + ONE;
        nxt.s  = res[DW-1];
        nxt.zval = res;
        nxt.b5 = res[5];
        nxt.b3 = res[3];
        nxt.h  = &opnd[3:0];
        nxt.pv = (opnd == POS_MAX);
        nxt.n  = 1'b0;
      end
      OP_DEC: begin
        res    = opnd - ONE;
        nxt.s  = res[DW-1];
        nxt.zval = res;
        nxt.b5 = res[5];
        nxt.b3 = res[3];
        nxt.h  = ~|opnd[3:0];
        nxt.pv = (opnd == NEG_MIN);
        nxt.n  = 1'b1;
      end
      OP_AND, OP_OR, OP_XOR: begin
        if (op == OP_AND)     res = acc & opnd;
        else if (op == OP_OR) res = acc | opnd;
        else                  res = acc ^ opnd;
        nxt.s  = res[DW-1];
        nxt.zval = res;
        nxt.b5 = res[5];
        nxt.b3 = res[3];
        nxt.h  = (op == OP_AND);
        nxt.pv = ~^res;
        nxt.n  = 1'b0;
        nxt.c  = 1'b0;
      end
      OP_RLT, OP_RLC: begin
        res    = {acc[DW-2:0], (op == OP_RLT) ? cur.c : acc[DW-1]};
        nxt.b5 = res[5];
        nxt.b3 = res[3];
        nxt.h  = 1'b0;
        nxt.n  = 1'b0;
        nxt.c  = acc[DW-1];
      end
      default: begin
        res = '0;
      end
    endcase
  end
endmodule

// File: rtl/alu8_widepath.sv
module alu8_widepath
  import alu8_pkg::*;
(
  input  logic [WW-1:0] wa,
  input  logic [WW-1:0] wb,
  input  flag_state_t   cur,
  output logic [WW-1:0] sum,
  output flag_state_t   nxt
);
  logic [WW:0] full;

  always_comb begin
    full   = {1'b0, wa} + {1'b0, wb};
    sum    = full[WW-1:0];
    nxt    = cur;
    nxt.c  = full[WW];
    nxt.h  = full[HB] ^ wa[HB] ^ wb[HB];
    nxt.b5 = full[DW+5];
    nxt.b3 = full[DW+3];
    nxt.n  = 1'b0;
  end
endmodule

// File: rtl/alu8_flagreg.sv
module alu8_flagreg
  import alu8_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ld,
  input  logic [7:0]    ld_byte,
  input  logic          upd,
  input  flag_state_t   nxt,
  output flag_state_t   state,
  output logic [7:0]    packed_flags
);
  flag_state_t state_q, state_d;

  always_comb begin
    state_d = state_q;
    if (ld) begin
      state_d.s    = ld_byte[7];
      state_d.zval = {DW{~ld_byte[6]}};
      state_d.b5   = ld_byte[5];
      state_d.h    = ld_byte[4];
      state_d.b3   = ld_byte[3];
      state_d.pv   = ld_byte[2];
      state_d.n    = ld_byte[1];
      state_d.c    = ld_byte[0];
    end else if (upd) begin
      state_d = nxt;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q.s    <= 1'b0;
      state_q.zval <= '1;
      state_q.b5   <= 1'b0;
      state_q.h    <= 1'b0;
      state_q.b3   <= 1'b0;
      state_q.pv   <= 1'b0;
      state_q.n    <= 1'b0;
      state_q.c    <= 1'b0;
    end else if (ld || upd) begin
      state_q <= state_d;
    end
  end

  assign state = state_q;
  assign packed_flags = {state_q.s, ~|state_q.zval, state_q.b5, state_q.h,
                         state_q.b3, state_q.pv, state_q.n, state_q.c};

  // R9: a load restores the byte exactly
  assert_load_restores_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ld |=> packed_flags == $past(ld_byte));
  // R10: no load and no update leaves the register alone
  assert_hold_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!ld && !upd) |=> $stable(packed_flags));
endmodule

// File: rtl/alu8_flagcore.sv
module alu8_flagcore
  import alu8_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          upd_en,
  input  logic [2:0]    op_sel,
  input  logic [DW-1:0] acc_in,
  input  logic [DW-1:0] opnd_in,
  input  logic [WW-1:0] wide_a,
  input  logic [WW-1:0] wide_b,
  input  logic          flag_ld,
  input  logic [7:0]    flag_ld_data,
  output logic [DW-1:0] res_byte,
  output logic [WW-1:0] res_wide,
  output logic [7:0]    flag_byte
);
  logic [SYNC_STAGES-1:0] rst_pipe;
  logic                   rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[SYNC_STAGES-2:0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[SYNC_STAGES-1];

  alu_op_e     op_e;
  flag_state_t cur_state, byte_nxt, wide_nxt, sel_nxt;

  assign op_e = alu_op_e'(op_sel);

  alu8_bytepath u_byte (
    .op   (op_e),
    .acc  (acc_in),
    .opnd (opnd_in),
    .cur  (cur_state),
    .res  (res_byte),
    .nxt  (byte_nxt)
  );

  alu8_widepath u_wide (
    .wa   (wide_a),
    .wb   (wide_b),
    .cur  (cur_state),
    .sum  (res_wide),
    .nxt  (wide_nxt)
  );

  assign sel_nxt = (op_e == OP_ADDW) ? wide_nxt : byte_nxt;

  alu8_flagreg u_flags (
    .clk          (clk),
    .rst_n        (rst_sync_n),
    .ld           (flag_ld),
    .ld_byte      (flag_ld_data),
    .upd          (upd_en),
    .nxt          (sel_nxt),
    .state        (cur_state),
    .packed_flags (flag_byte)
  );

  logic commit;
  assign commit = upd_en && !flag_ld;

  // R2 R3: increment and decrement leave carry alone
  assert_incdec_keep_carry_R2: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (commit && (op_e == OP_INC || op_e == OP_DEC)) |=> flag_byte[0] == $past(flag_byte[0]));
  // R4: logic ops clear subtract and carry
  assert_logic_clear_nc_R4: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (commit && (op_e == OP_AND || op_e == OP_OR || op_e == OP_XOR)) |=> flag_byte[1:0] == 2'b00);
  // R6 R7: both rotates take carry from accumulator bit 7
  assert_rotate_carry_R6: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (commit && (op_e == OP_RLT || op_e == OP_RLC)) |=> flag_byte[0] == $past(acc_in[DW-1]));
  // R8: wide add keeps sign, zero and parity
  assert_wide_keeps_szp_R8: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (commit && op_e == OP_ADDW) |=> (flag_byte[7] == $past(flag_byte[7]) &&
                                     flag_byte[6] == $past(flag_byte[6]) &&
                                     flag_byte[2] == $past(flag_byte[2])));
endmodule

// File: tb/alu8_flagcore_bench.sv
module alu8_flagcore_bench;
  localparam int CLK_PERIOD = 10;
  localparam int WDOG_CYCLES = 150000;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        upd_en, flag_ld;
  logic [2:0]  op_sel;
  logic [7:0]  acc_in, opnd_in, flag_ld_data;
  logic [15:0] wide_a, wide_b;
  logic [7:0]  res_byte, flag_byte;
  logic [15:0] res_wide;

  int nchk = 0;
  int nfail = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  alu8_flagcore u_alu8_flagcore (
    .clk(clk), .rst_n(rst_n), .upd_en(upd_en), .op_sel(op_sel),
    .acc_in(acc_in), .opnd_in(opnd_in), .wide_a(wide_a), .wide_b(wide_b),
    .flag_ld(flag_ld), .flag_ld_data(flag_ld_data),
    .res_byte(res_byte), .res_wide(res_wide), .flag_byte(flag_byte)
  );

  task automatic chk(string tag, logic [15:0] act, logic [15:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Returns {result byte, flag byte}
  function automatic logic [15:0] model(int op, logic [7:0] a, logic [7:0] x,
                                        logic [7:0] seed, logic [15:0] wa, logic [15:0] wb);
    logic [7:0]  r = 8'h00;
    logic [7:0]  f = seed;
    logic [16:0] s;
    int          lo;
    case (op)
      0: begin
        r = x + 8'd1;
        f[7] = r[7]; f[6] = (r == 0); f[5] = r[5]; f[3] = r[3];
        f[4] = (x[3:0] == 4'hF); f[2] = (x == 8'h7F); f[1] = 1'b0;
      end
      1: begin
        r = x - 8'd1;
        f[7] = r[7]; f[6] = (r == 0); f[5] = r[5]; f[3] = r[3];
        f[4] = (x[3:0] == 4'h0); f[2] = (x == 8'h80); f[1] = 1'b1;
      end
      2, 3, 4: begin
        r = (op == 2) ? (a & x) : (op == 3) ? (a | x) : (a ^ x);
        f[7] = r[7]; f[6] = (r == 0); f[5] = r[5]; f[3] = r[3];
        f[4] = (op == 2); f[2] = ($countones(r) % 2 == 0); f[1] = 1'b0; f[0] = 1'b0;
      end
      5, 6: begin
        r = {a[6:0], (op == 5) ? seed[0] : a[7]};
        f[5] = r[5]; f[3] = r[3]; f[4] = 1'b0; f[1] = 1'b0; f[0] = a[7];
      end
      default: begin
        s  = {1'b0, wa} + {1'b0, wb};
        lo = int'(wa & 16'h0FFF) + int'(wb & 16'h0FFF);
        f[5] = s[13]; f[3] = s[11]; f[4] = (lo >= 4096); f[1] = 1'b0; f[0] = s[16];
      end
    endcase
    return {r, f};
  endfunction

  task automatic apply(int op, logic [7:0] a, logic [7:0] x, logic [7:0] seed,
                       logic [15:0] wa, logic [15:0] wb, string tag);
    logic [15:0] m;
    m = model(op, a, x, seed, wa, wb);
    @(negedge clk);
    flag_ld = 1'b1; flag_ld_data = seed; upd_en = 1'b0;
    @(negedge clk);
    flag_ld = 1'b0; upd_en = 1'b1; op_sel = op[2:0];
    acc_in = a; opnd_in = x; wide_a = wa; wide_b = wb;
    #1;
    if (op == 7) chk({tag, " sum"}, res_wide, wa + wb);
    else         chk({tag, " result"}, {8'h00, res_byte}, {8'h00, m[15:8]});
    @(negedge clk);
    upd_en = 1'b0;
    chk({tag, " flags"}, {8'h00, flag_byte}, {8'h00, m[7:0]});
  endtask

  initial begin
    repeat (WDOG_CYCLES) @(posedge clk);
    if (!done) begin
      nfail++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; upd_en = 1'b0; flag_ld = 1'b0; op_sel = 3'd0;
    acc_in = 8'h00; opnd_in = 8'h00; flag_ld_data = 8'h00;
    wide_a = 16'h0000; wide_b = 16'h0000;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1 reset flags", {8'h00, flag_byte}, 16'h0000);

    // R2 / R3 sweeps: every operand, two seed families
    for (int x = 0; x < 256; x++) begin
      apply(0, 8'h00, 8'(x), 8'(x * 37 + 91), 16'h0, 16'h0, "R2 inc");
      apply(0, 8'h00, 8'(x), 8'(~(x * 37 + 91)), 16'h0, 16'h0, "R2 inc");
      apply(1, 8'h00, 8'(x), 8'(x * 53 + 7), 16'h0, 16'h0, "R3 dec");
      apply(1, 8'h00, 8'(x), 8'(~(x * 53 + 7)), 16'h0, 16'h0, "R3 dec");
    end

    // R4 / R5: logic operations
    for (int op = 2; op <= 4; op++)
      for (int k = 0; k < 16; k++)
        for (int x = 0; x < 256; x++)
          apply(op, 8'(k * 17 + (k >> 1)), 8'(x), 8'(x * 29 + k), 16'h0, 16'h0, "R4 R5 logic");

    // R6 / R7: rotates with both carry values
    for (int a = 0; a < 256; a++) begin
      apply(5, 8'(a), 8'h00, 8'(a * 11) & 8'hFE, 16'h0, 16'h0, "R6 rotate-thru");
      apply(5, 8'(a), 8'h00, 8'(a * 11) | 8'h01, 16'h0, 16'h0, "R6 rotate-thru");
      apply(6, 8'(a), 8'h00, 8'(a * 13) & 8'hFE, 16'h0, 16'h0, "R7 rotate-circ");
      apply(6, 8'(a), 8'h00, 8'(a * 13) | 8'h01, 16'h0, 16'h0, "R7 rotate-circ");
    end

    // R8: wide add corners then pseudo-random
    apply(7, 8'h00, 8'h00, 8'hC4, 16'hFFFF, 16'h0001, "R8 wide");
    apply(7, 8'h00, 8'h00, 8'h00, 16'h0FFF, 16'h0001, "R8 wide");
    apply(7, 8'h00, 8'h00, 8'hFF, 16'h8000, 16'h8000, "R8 wide");
    apply(7, 8'h00, 8'h00, 8'h3B, 16'h0000, 16'h0000, "R8 wide");
    for (int i = 0; i < 1200; i++)
      apply(7, 8'h00, 8'h00, 8'(i * 71), 16'(i * 40503 + 12345), 16'(i * 9973 ^ 16'h5A5A), "R8 wide");

    // R9: load beats update
    @(negedge clk);
    flag_ld = 1'b1; flag_ld_data = 8'h6D; upd_en = 1'b1; op_sel = 3'd0; opnd_in = 8'hFF;
    @(negedge clk);
    flag_ld = 1'b0; upd_en = 1'b0;
    chk("R9 load over update", {8'h00, flag_byte}, 16'h006D);
    for (int v = 0; v < 256; v += 51) begin
      @(negedge clk);
      flag_ld = 1'b1; flag_ld_data = 8'(v);
      @(negedge clk);
      flag_ld = 1'b0;
      chk("R9 load", {8'h00, flag_byte}, 16'(v));
    end

    // R10: idle cycles with changing inputs keep flags
    @(negedge clk);
    flag_ld = 1'b1; flag_ld_data = 8'hA5;
    @(negedge clk);
    flag_ld = 1'b0;
    for (int op = 0; op < 8; op++) begin
      op_sel = op[2:0]; acc_in = 8'hFF; opnd_in = 8'h7F;
      wide_a = 16'hFFFF; wide_b = 16'h0001;
      @(negedge clk);
      chk("R10 hold", {8'h00, flag_byte}, 16'h00A5);
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule